// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This peripheral keeps time for a chip that sleeps. A 47-bit count advances on every pulse of a slow tick enable that stands for a 32.768 kHz clock. The low 15 bits of that count are the fraction of a second and the upper 32 bits are whole seconds. A 32-bit seconds alarm is compared with the whole-second part. When they match, a sticky pending flag is set, and that flag drives a level alarm interrupt and a level wakeup request.

Software reaches the block over a plain 32-bit register bus with an address, a write enable, write data and combinational read data. Changes to the control bits do not act at once. They take effect, and show on readback, only after a fixed number of slow ticks, so software polls the control register until it reads back what was written. A new time is loaded only while counting is stopped, and a new alarm only while the alarm is disarmed. A scratch register holds an init key, and the block reports whether that key is present.

Top module: `lp_sec_counter`

## Requirements
- R1: After reset every register reads 0 (control, status, both count halves, alarm, init key), and both alarmIrq and wakeIrq are 0.
- R2: While the effective run bit is set, each slowTick adds 1 to the 47-bit count, which wraps from all ones to 0. Byte offset 0x20 reads count bits 31:0, and offset 0x1C reads count bits 46:32 in bits 14:0.
- R3: Control sits at offset 0x04, with bit 0 = run, bit 1 = alarm arm and bit 3 = wake enable. A written value takes effect, and shows on readback, on the second slowTick after the write. Until then readback shows the previous effective value.
- R4: Writes to offsets 0x20 and 0x1C load the count only while the effective run bit is 0. While run is 1 they are ignored.
- R5: The alarm register at offset 0x24 holds 32 seconds. A write to it is ignored while the effective alarm-arm bit is 1.
- R6: On a slowTick where alarm arm is set and count bits 46:15 equal the alarm value, the pending flag (status offset 0x18, bit 0) sets. alarmIrq = pending AND alarm arm.
- R7: Writing 1 to status bit 0 clears the pending flag, and writing 0 leaves it unchanged. A match that lasts many ticks within one second sets the flag only on its first tick, so clearing it during that second keeps it clear.
- R8: wakeIrq = pending AND the effective wake-enable bit.
- R9: Offset 0x30 stores and returns a 32-bit word. The output initOk is 1 exactly when that word equals 0x41736166.
- R10: Reads of any offset not listed above return 0.
- R11: With alarm arm clear, the pending flag does not set, even while the seconds equal the alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle pulse per slow-clock period |
| busAddr | input | 8 | Byte offset of the register |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| alarmIrq | output | 1 | Level alarm interrupt |
| wakeIrq | output | 1 | Level wakeup request |
| initOk | output | 1 | Init key register holds the expected value |

## Verification
The hardest state to reach from the ports is the edge of a second while the alarm is armed. To get there, the count has to be loaded while stopped, just below a second boundary, and then run through the two-tick control delay without stepping. The stimulus loads a value three steps short of second 9, arms the alarm with run and wake enable together, and counts ticks to the exact tick that crosses into the matching second. While the seconds value is still equal, it then checks the write-one-to-clear behaviour, the gating of the wake output and the rule that a match sets the flag once.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int CNT_W  = 47;
  localparam int FRAC_W = 15;
  localparam int SEC_W  = CNT_W - FRAC_W;
  localparam int HI_W   = CNT_W - 32;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_CNTHI = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_CNTLO = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_ALARM = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_KEY   = 8'h30;

  localparam logic [DATA_W-1:0] INIT_KEY = 32'h41736166;

  typedef struct packed {
    logic wake;
    logic arm;
    logic run;
  } ctrl_t;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrAlarm;
    logic clrPend;
    logic wrKey;
  } strobe_t;
endpackage

// File: rtl/lpc_ctrl.sv
module lpc_ctrl
  import lpc_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           stb,
  output ctrl_t             ctrlEff
);
  localparam int SC_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
  localparam logic [SC_W-1:0] SC_LAST = SC_W'(SYNC_TICKS - 1);

  ctrl_t           ctrlReq;
  logic [SC_W-1:0] syncCnt;
  logic            wrCtrl;

  assign wrCtrl = busWe && (busAddr == OFF_CTRL);

  always_comb begin
    stb         = '0;
    stb.wrLo    = busWe && (busAddr == OFF_CNTLO);
    stb.wrHi    = busWe && (busAddr == OFF_CNTHI);
    stb.wrAlarm = busWe && (busAddr == OFF_ALARM);
    stb.clrPend = busWe && (busAddr == OFF_STAT) && busWdata[0];
    stb.wrKey   = busWe && (busAddr == OFF_KEY);
  end

  // The requested value crosses to the effective copy only on slow ticks.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReq <= '0;
      ctrlEff <= '0;
      syncCnt <= '0;
    end else if (wrCtrl) begin
      ctrlReq <= '{wake: busWdata[3], arm: busWdata[1], run: busWdata[0]};
      syncCnt <= '0;
    end else if (slowTick && (ctrlReq != ctrlEff)) begin
      if (syncCnt == SC_LAST) begin
        ctrlEff <= ctrlReq;
        syncCnt <= '0;
      end else begin
        syncCnt <= syncCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  strobe_t           stb,
  input  ctrl_t             ctrlEff,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [SEC_W-1:0]  alarmVal,
  output logic              pend,
  output logic              initOk
);
  logic [DATA_W-1:0] keyWord;
  logic              secEq;
  logic              prevEq;

  assign secEq  = (cnt[CNT_W-1:FRAC_W] == alarmVal);
  assign initOk = (keyWord == INIT_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctrlEff.run) begin
      if (slowTick) cnt <= cnt + 1'b1;
    end else begin
      if (stb.wrLo) cnt[31:0]      <= busWdata;
      if (stb.wrHi) cnt[CNT_W-1:32] <= busWdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmVal <= '0;
      keyWord  <= '0;
    end else begin
      if (stb.wrAlarm && !ctrlEff.arm) alarmVal <= busWdata;
      if (stb.wrKey) keyWord <= busWdata;
    end
  end

  // A match sets the flag only on the first tick of an equal second.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend   <= 1'b0;
      prevEq <= 1'b0;
    end else begin
      if (slowTick) prevEq <= secEq;
      if (slowTick && ctrlEff.arm && secEq && !prevEq) pend <= 1'b1;
      else if (stb.clrPend) pend <= 1'b0;
    end
  end

  always_comb begin
    unique case (busAddr)
      OFF_CTRL:  busRdata = {28'd0, ctrlEff.wake, 1'b0, ctrlEff.arm, ctrlEff.run};
      OFF_STAT:  busRdata = {31'd0, pend};
      OFF_CNTHI: busRdata = {{(DATA_W-HI_W){1'b0}}, cnt[CNT_W-1:32]};
      OFF_CNTLO: busRdata = cnt[31:0];
      OFF_ALARM: busRdata = alarmVal;
      OFF_KEY:   busRdata = keyWord;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/lp_sec_counter.sv
module lp_sec_counter
  import lpc_pkg::*;
#(
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              alarmIrq,
  output logic              wakeIrq,
  output logic              initOk
);
  strobe_t             stb;
  ctrl_t               ctrlEff;
  logic [CNT_W-1:0]    cnt;
  logic [SEC_W-1:0]    alarmVal;
  logic                pend;

  lpc_ctrl #(.SYNC_TICKS(SYNC_TICKS)) uCtl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .stb(stb), .ctrlEff(ctrlEff)
  );

  lpc_datapath uDp (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .stb(stb), .ctrlEff(ctrlEff),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .cnt(cnt),
    .alarmVal(alarmVal), .pend(pend), .initOk(initOk)
  );

  assign alarmIrq = pend && ctrlEff.arm;
  assign wakeIrq  = pend && ctrlEff.wake;
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker
  import lpc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             slowTick,
  input logic             busWe,
  input logic             alarmIrq,
  input logic             wakeIrq,
  input logic [CNT_W-1:0] cnt,
  input logic [SEC_W-1:0] alarmVal,
  input logic             pend,
  input logic             run,
  input logic             arm,
  input logic             wake
);
  // R2: each tick while running advances the count by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (slowTick && run) |=> (cnt == $past(cnt) + 1'b1));

  // R4: without a tick and without a write, the count holds
  a_r4_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!slowTick && !busWe) |=> $stable(cnt));

  // R3: effective control changes only on a slow tick
  a_r3_ctrl_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    !slowTick |=> ($stable(run) && $stable(arm) && $stable(wake)));

  // R5: armed alarm value is frozen
  a_r5_alarm_frozen: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> $stable(alarmVal));

  // R6: pending rises only on a tick with the alarm armed
  a_r6_set_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pend) |-> ($past(slowTick) && $past(arm)));

  // R6: interrupt only when armed
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rstN)
    alarmIrq |-> (pend && arm));

  // R8: wake only when enabled
  a_r8_wake_gated: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> (pend && wake));
endmodule

bind lp_sec_counter lpc_checker uChk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWe(busWe),
  .alarmIrq(alarmIrq), .wakeIrq(wakeIrq), .cnt(cnt), .alarmVal(alarmVal),
  .pend(pend), .run(ctrlEff.run), .arm(ctrlEff.arm), .wake(ctrlEff.wake)
);

// File: tb/sim_lp_sec_counter.sv
`timescale 1ns/1ps
module sim_lp_sec_counter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        alarmIrq, wakeIrq, initOk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lp_sec_counter u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata),
    .alarmIrq(alarmIrq), .wakeIrq(wakeIrq), .initOk(initOk)
  );

  localparam int NV = 5;
  localparam logic [14:0] V_HI [NV] = '{15'h0000, 15'h0000, 15'h7FFF, 15'h7FFF, 15'h0123};
  localparam logic [31:0] V_LO [NV] = '{32'h0, 32'h00007FFE, 32'hFFFFFFFC, 32'hFFFFFFFF, 32'h89ABCDEF};
  localparam int          V_TK [NV] = '{5, 3, 1, 4, 100};

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic tick();
    @(negedge clk);
    slowTick = 1'b1;
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic setCtrl(input logic [31:0] v);
    wr(8'h04, v);
    tick();
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog got=hung exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [46:0] expCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h04, r); chk("R1 ctrl", r, 0);
    rd(8'h18, r); chk("R1 stat", r, 0);
    rd(8'h1C, r); chk("R1 hi", r, 0);
    rd(8'h20, r); chk("R1 lo", r, 0);
    rd(8'h24, r); chk("R1 alarm", r, 0);
    rd(8'h30, r); chk("R1 key", r, 0);
    chk("R1 irqs", {30'd0, alarmIrq, wakeIrq}, 0);

    // R2 vector table: load, run N ticks, stop (stop adds 2 ticks of count)
    for (int i = 0; i < NV; i++) begin
      wr(8'h20, V_LO[i]);
      wr(8'h1C, {17'd0, V_HI[i]});
      setCtrl(32'h1);
      for (int k = 0; k < V_TK[i]; k++) tick();
      setCtrl(32'h0);
      expCnt = {V_HI[i], V_LO[i]} + 47'(V_TK[i] + 2);
      rd(8'h20, r); chk("R2 lo", r, expCnt[31:0]);
      rd(8'h1C, r); chk("R2 hi", r, {17'd0, expCnt[46:32]});
    end

    // R11: alarm value 0 met at start of vector 0, but alarm disarmed
    rd(8'h18, r); chk("R11 no pend", r, 0);

    // R3 sync delay
    wr(8'h04, 32'h1);
    rd(8'h04, r); chk("R3 before tick", r, 0);
    tick();
    rd(8'h04, r); chk("R3 after 1 tick", r, 0);
    tick();
    rd(8'h04, r); chk("R3 after 2 ticks", r, 1);
    setCtrl(32'h0);

    // Alarm sequence: count 3 steps short of second 9
    wr(8'h20, 32'h00047FFD);
    wr(8'h1C, 32'h0);
    wr(8'h24, 32'd9);
    rd(8'h24, r); chk("R5 alarm load", r, 9);
    setCtrl(32'hB);
    rd(8'h04, r); chk("R3 ctrl B", r, 32'hB);
    tick(); tick(); tick();
    rd(8'h18, r); chk("R6 not yet", r, 0);
    tick();
    rd(8'h18, r); chk("R6 pend", r, 1);
    chk("R6 alarmIrq", {31'd0, alarmIrq}, 1);
    chk("R8 wakeIrq on", {31'd0, wakeIrq}, 1);
    wr(8'h24, 32'd5);
    rd(8'h24, r); chk("R5 armed write ignored", r, 9);
    wr(8'h20, 32'h0);
    rd(8'h20, r); chk("R4 running write ignored", r, 32'h00048001);
    setCtrl(32'h3);
    chk("R8 wakeIrq off", {31'd0, wakeIrq}, 0);
    chk("R8 alarmIrq stays", {31'd0, alarmIrq}, 1);
    rd(8'h20, r); chk("R4 still counting", r, 32'h00048003);
    wr(8'h18, 32'h0);
    rd(8'h18, r); chk("R7 write 0 keeps", r, 1);
    wr(8'h18, 32'h1);
    rd(8'h18, r); chk("R7 write 1 clears", r, 0);
    chk("R7 irq clear", {31'd0, alarmIrq}, 0);
    tick();
    rd(8'h18, r); chk("R7 once per second", r, 0);
    setCtrl(32'h0);

    // R9 init key
    chk("R9 initOk low", {31'd0, initOk}, 0);
    wr(8'h30, 32'h41736166);
    rd(8'h30, r); chk("R9 key readback", r, 32'h41736166);
    chk("R9 initOk high", {31'd0, initOk}, 1);
    wr(8'h30, 32'h41736167);
    chk("R9 initOk wrong key", {31'd0, initOk}, 0);

    // R10 unmapped offsets
    rd(8'h08, r); chk("R10 unmapped 08", r, 0);
    rd(8'h2C, r); chk("R10 unmapped 2C", r, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule